// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command pins of a four-bank SDRAM on every rising clock edge. It decodes each sampled command and keeps its own record of which banks hold an open row. It then compares the command against the minimum spacing rules, given in clocks as parameters, that separate it from earlier related commands. It never drives the memory. It sits beside a controller or a memory model and reports, one clock later, the decoded command, the open-row flags and a separate one-cycle pulse for each kind of rule that was broken.

Spacing is counted in clock edges. A command sampled at edge t2 lies d = t2 - t1 clocks after one sampled at edge t1, and a rule with limit N is broken when d < N. Per-bank and shared down-counters are loaded when the relevant command is seen. Each command is checked against the counters as they stand just before its own edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: On each edge the sampled pins decode to a 4-bit code, and `cmd_o` shows that code one clock later. The codes are: CS_n high gives 0 (no-op). With CS_n low and {RAS_n,CAS_n,WE_n}: 111 gives 0, 000 gives 1 (mode set), 001 gives 2 (auto refresh) with CKE high and 3 (self refresh entry) with CKE low, 011 gives 4 (activate), 101 gives 5 (read), 100 gives 6 (write), 110 gives 7 (burst stop), and 010 gives 8 (precharge). With CKE low, every pattern except the refresh pattern gives 0.
- R2: `bank_open_o[n]` is bit n for bank address n and updates one clock after the command edge. It is set by activate to bank n. It is cleared by precharge to bank n with A10 low, by precharge with A10 high (all banks, whatever the bank address), and by read or write to open bank n with A10 high (auto-precharge).
- R3: An activate issued fewer than T_RRD clocks after an activate to a different bank pulses `viol_rrd_o`. A second activate to the same bank does not.
- R4: A read or write issued fewer than T_RCD clocks after an activate of that bank pulses `viol_rcd_o`.
- R5: A precharge that closes an open bank fewer than T_RAS clocks after that bank's activate pulses `viol_ras_o`. This includes precharge-all.
- R6: An activate pulses `viol_rp_o` if it comes too soon after its bank was closed. The minimum spacing is T_RP clocks after a precharge, BURST_LEN+T_RP clocks after a read with auto-precharge, and BURST_LEN-1+T_WR+T_RP clocks after a write with auto-precharge.
- R7: An activate issued fewer than T_RC clocks after the previous activate of the same bank pulses `viol_rc_o`.
- R8: A precharge that closes an open bank fewer than BURST_LEN-1+T_WR clocks after a write to that bank pulses `viol_wr_o`.
- R9: Any command other than no-op issued fewer than T_MRD clocks after a mode set pulses `viol_mrd_o`.
- R10: `viol_state_o` pulses for any of the following: a read or write to a closed bank, an activate to an open bank, or a mode set, auto refresh or self refresh entry while any bank is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank / auto-precharge select) |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_open_o | output | 2**BA_W | Open-row flag per bank |
| viol_rrd_o | output | 1 | Cross-bank activate spacing broken |
| viol_rcd_o | output | 1 | Activate-to-column spacing broken |
| viol_rp_o | output | 1 | Close-to-activate spacing broken |
| viol_ras_o | output | 1 | Minimum row active time broken |
| viol_rc_o | output | 1 | Same-bank activate spacing broken |
| viol_wr_o | output | 1 | Write recovery before precharge broken |
| viol_mrd_o | output | 1 | Command too soon after mode set |
| viol_state_o | output | 1 | Command illegal for current bank state |

## Verification
The properties assume that reset is held for at least two clocks, so that the sampled history of the open flags is defined once checking starts. They also assume that pin values are settled at each rising edge. Beyond that, no legal command stream is assumed: the properties tie each violation pulse to the command class that can cause it. The stimulus changes pins only on falling edges and starts each timing sweep from a fresh reset. Earlier counters therefore never mix into the spacing under test, and every distance around each limit is driven once.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_WR   = 4'd6,
        CMD_BST  = 4'd7,
        CMD_PRE  = 4'd8
    } cmd_e;

    typedef struct packed {
        logic rcd;
        logic rp;
        logic ras;
        logic rc;
        logic wr;
        logic state;
    } bank_viol_t;

    typedef struct packed {
        logic rrd;
        logic rcd;
        logic rp;
        logic ras;
        logic rc;
        logic wr;
        logic mrd;
        logic state;
    } viol_t;

    function automatic cmd_e decode_pins(input logic cke, input logic cs_n,
                                         input logic ras_n, input logic cas_n,
                                         input logic we_n);
        cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            if (cke) begin
                unique case ({ras_n, cas_n, we_n})
                    3'b000:  c = CMD_MRS;
                    3'b001:  c = CMD_REF;
                    3'b011:  c = CMD_ACT;
                    3'b101:  c = CMD_RD;
                    3'b100:  c = CMD_WR;
                    3'b110:  c = CMD_BST;
                    3'b010:  c = CMD_PRE;
                    default: c = CMD_NOP;
                endcase
            end else if ({ras_n, cas_n, we_n} == 3'b001) begin
                c = CMD_SREF;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcm_decoder.sv
module sdcm_decoder
    import sdcm_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e op
);
    always_comb op = decode_pins(cke, cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdcm_down_counter.sv
module sdcm_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
    import sdcm_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_e       op,
    input  logic       hit,
    input  logic       ap,
    output logic       open_o,
    output bank_viol_t viol_o
);
    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(BURST_LEN + T_WR - 2);
    localparam logic [CNT_W-1:0] APR_LD = CNT_W'(BURST_LEN + T_RP - 1);
    localparam logic [CNT_W-1:0] APW_LD = CNT_W'(BURST_LEN + T_WR + T_RP - 2);

    logic open_q;
    logic is_act, is_col, is_wr, is_pre, closing_pre, closing_ap;
    logic rcd_busy, ras_busy, rc_busy, rp_busy, wr_busy;
    logic rp_load;
    logic [CNT_W-1:0] rp_val;

    always_comb begin
        is_act      = (op == CMD_ACT) && hit;
        is_wr       = (op == CMD_WR) && hit;
        is_col      = ((op == CMD_RD) || (op == CMD_WR)) && hit;
        is_pre      = (op == CMD_PRE) && (ap || hit);
        closing_pre = is_pre && open_q;
        closing_ap  = is_col && ap && open_q;
        rp_load     = closing_pre || closing_ap;
        if (is_pre)     rp_val = RP_LD;
        else if (is_wr) rp_val = APW_LD;
        else            rp_val = APR_LD;
    end

    sdcm_down_counter #(.W(CNT_W)) u_rcd (.clk(clk), .rst(rst), .load(is_act),
        .load_val(RCD_LD), .busy(rcd_busy));
    sdcm_down_counter #(.W(CNT_W)) u_ras (.clk(clk), .rst(rst), .load(is_act),
        .load_val(RAS_LD), .busy(ras_busy));
    sdcm_down_counter #(.W(CNT_W)) u_rc  (.clk(clk), .rst(rst), .load(is_act),
        .load_val(RC_LD), .busy(rc_busy));
    sdcm_down_counter #(.W(CNT_W)) u_rp  (.clk(clk), .rst(rst), .load(rp_load),
        .load_val(rp_val), .busy(rp_busy));
    sdcm_down_counter #(.W(CNT_W)) u_wr  (.clk(clk), .rst(rst), .load(is_wr),
        .load_val(WR_LD), .busy(wr_busy));

    always_ff @(posedge clk) begin
        if (rst)                        open_q <= 1'b0;
        else if (is_act)                open_q <= 1'b1;
        else if (is_pre || closing_ap)  open_q <= 1'b0;
    end

    always_comb begin
        viol_o.rcd   = is_col && rcd_busy;
        viol_o.rp    = is_act && rp_busy;
        viol_o.rc    = is_act && rc_busy;
        viol_o.ras   = closing_pre && ras_busy;
        viol_o.wr    = closing_pre && wr_busy;
        viol_o.state = (is_col && !open_q) || (is_act && open_q);
    end

    assign open_o = open_q;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_W-1:0]       ba,
    input  logic                  a10,
    output logic [3:0]            cmd_o,
    output logic [(1<<BA_W)-1:0]  bank_open_o,
    output logic                  viol_rrd_o,
    output logic                  viol_rcd_o,
    output logic                  viol_rp_o,
    output logic                  viol_ras_o,
    output logic                  viol_rc_o,
    output logic                  viol_wr_o,
    output logic                  viol_mrd_o,
    output logic                  viol_state_o
);
    localparam int NB    = 1 << BA_W;
    localparam int CNT_W = $clog2(T_RC + T_RAS + T_RP + T_WR + T_RRD + T_MRD + BURST_LEN + 1);
    localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(T_RRD - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);

    cmd_e            op;
    cmd_e            cmd_q;
    logic [NB-1:0]   open_q;
    bank_viol_t      bank_v [NB];
    viol_t           viol_d, viol_q;
    logic            rrd_busy, mrd_busy;
    logic [BA_W-1:0] last_act_ba;
    logic            is_act, is_mrs;

    sdcm_decoder u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        sdcm_bank #(
            .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
            .T_RC(T_RC), .T_WR(T_WR), .BURST_LEN(BURST_LEN)
        ) u_bank (
            .clk(clk), .rst(rst), .op(op), .hit(ba == BA_W'(g)), .ap(a10),
            .open_o(open_q[g]), .viol_o(bank_v[g])
        );
    end

    assign is_act = (op == CMD_ACT);
    assign is_mrs = (op == CMD_MRS);

    sdcm_down_counter #(.W(CNT_W)) u_rrd (.clk(clk), .rst(rst), .load(is_act),
        .load_val(RRD_LD), .busy(rrd_busy));
    sdcm_down_counter #(.W(CNT_W)) u_mrd (.clk(clk), .rst(rst), .load(is_mrs),
        .load_val(MRD_LD), .busy(mrd_busy));

    always_ff @(posedge clk) begin
        if (rst)         last_act_ba <= '0;
        else if (is_act) last_act_ba <= ba;
    end

    always_comb begin
        viol_d       = '0;
        viol_d.rrd   = is_act && rrd_busy && (ba != last_act_ba);
        viol_d.mrd   = (op != CMD_NOP) && mrd_busy;
        viol_d.state = ((op == CMD_MRS) || (op == CMD_REF) || (op == CMD_SREF)) && (|open_q);
        for (int b = 0; b < NB; b++) begin
            viol_d.rcd   = viol_d.rcd   | bank_v[b].rcd;
            viol_d.rp    = viol_d.rp    | bank_v[b].rp;
            viol_d.ras   = viol_d.ras   | bank_v[b].ras;
            viol_d.rc    = viol_d.rc    | bank_v[b].rc;
            viol_d.wr    = viol_d.wr    | bank_v[b].wr;
            viol_d.state = viol_d.state | bank_v[b].state;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            viol_q <= '0;
        end else begin
            cmd_q  <= op;
            viol_q <= viol_d;
        end
    end

    assign cmd_o        = cmd_q;
    assign bank_open_o  = open_q;
    assign viol_rrd_o   = viol_q.rrd;
    assign viol_rcd_o   = viol_q.rcd;
    assign viol_rp_o    = viol_q.rp;
    assign viol_ras_o   = viol_q.ras;
    assign viol_rc_o    = viol_q.rc;
    assign viol_wr_o    = viol_q.wr;
    assign viol_mrd_o   = viol_q.mrd;
    assign viol_state_o = viol_q.state;
endmodule

// File: rtl/sdcm_checker.sv
module sdcm_checker #(
    parameter int BA_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic                 a10,
    input logic [3:0]           cmd_o,
    input logic [(1<<BA_W)-1:0] bank_open_o,
    input logic                 viol_rrd_o,
    input logic                 viol_rcd_o,
    input logic                 viol_rp_o,
    input logic                 viol_ras_o,
    input logic                 viol_rc_o,
    input logic                 viol_wr_o,
    input logic                 viol_mrd_o,
    input logic                 viol_state_o
);
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (cke && !cs_n && !ras_n && cas_n && we_n) |=> bank_open_o[$past(ba)]);

    assert_pre_all_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (cke && !cs_n && !ras_n && cas_n && !we_n && a10) |=> (bank_open_o == '0));

    // R3, R6 and R7 pulses belong to activate only
    assert_act_rules_R3: assert property (@(posedge clk) disable iff (rst)
        (viol_rrd_o || viol_rp_o || viol_rc_o) |-> (cmd_o == 4'd4));

    assert_col_rule_R4: assert property (@(posedge clk) disable iff (rst)
        viol_rcd_o |-> ((cmd_o == 4'd5) || (cmd_o == 4'd6)));

    // R5 and R8 pulses belong to precharge only
    assert_pre_rules_R5: assert property (@(posedge clk) disable iff (rst)
        (viol_ras_o || viol_wr_o) |-> (cmd_o == 4'd8));

    assert_mrd_real_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        viol_mrd_o |-> (cmd_o != 4'd0));

    assert_closed_for_mode_R10: assert property (@(posedge clk) disable iff (rst)
        (((cmd_o == 4'd1) || (cmd_o == 4'd2) || (cmd_o == 4'd3)) && ($past(bank_open_o) != '0))
        |-> viol_state_o);
endmodule

bind sdram_cmd_monitor sdcm_checker #(.BA_W(BA_W)) u_sdcm_checker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
    .viol_rrd_o(viol_rrd_o), .viol_rcd_o(viol_rcd_o), .viol_rp_o(viol_rp_o),
    .viol_ras_o(viol_ras_o), .viol_rc_o(viol_rc_o), .viol_wr_o(viol_wr_o),
    .viol_mrd_o(viol_mrd_o), .viol_state_o(viol_state_o)
);

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;
    localparam int CLK_P = 10;
    localparam int T_RRD = 2, T_RCD = 3, T_RP = 3, T_RAS = 7, T_RC = 10;
    localparam int T_WR = 2, T_MRD = 2, BL = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic a10 = 1'b0;
    logic [3:0] cmd_o;
    logic [3:0] bank_open_o;
    logic v_rrd, v_rcd, v_rp, v_ras, v_rc, v_wr, v_mrd, v_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sdram_cmd_monitor #(
        .BA_W(2), .T_RRD(T_RRD), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD), .BURST_LEN(BL)
    ) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
        .viol_rrd_o(v_rrd), .viol_rcd_o(v_rcd), .viol_rp_o(v_rp), .viol_ras_o(v_ras),
        .viol_rc_o(v_rc), .viol_wr_o(v_wr), .viol_mrd_o(v_mrd), .viol_state_o(v_state)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // code per R1: 0 nop,1 mode set,2 refresh,3 self refresh,4 act,5 rd,6 wr,7 bst,8 pre
    task automatic put(input int c, input int b, input bit ap);
        cke = 1'b1; cs_n = 1'b0;
        case (c)
            1: {ras_n, cas_n, we_n} = 3'b000;
            2: {ras_n, cas_n, we_n} = 3'b001;
            3: begin cke = 1'b0; {ras_n, cas_n, we_n} = 3'b001; end
            4: {ras_n, cas_n, we_n} = 3'b011;
            5: {ras_n, cas_n, we_n} = 3'b101;
            6: {ras_n, cas_n, we_n} = 3'b100;
            7: {ras_n, cas_n, we_n} = 3'b110;
            8: {ras_n, cas_n, we_n} = 3'b010;
            default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
        endcase
        ba = 2'(b);
        a10 = ap;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    function automatic int ref_code(input int k);
        bit ck, cs, r, c, w;
        ck = k[4]; cs = k[3]; r = k[2]; c = k[1]; w = k[0];
        if (cs) return 0;
        if (!ck) return ({r, c, w} == 3'b001) ? 3 : 0;
        case ({r, c, w})
            3'b000: return 1;
            3'b001: return 2;
            3'b011: return 4;
            3'b101: return 5;
            3'b100: return 6;
            3'b110: return 7;
            3'b010: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Reset state: R1 and R2
        chk("R1 reset cmd", cmd_o, 0);
        chk("R2 reset open", bank_open_o, 0);
        chk("R10 reset viol", {v_rrd, v_rcd, v_rp, v_ras, v_rc, v_wr, v_mrd, v_state}, 0);

        // R1: full decode sweep
        for (int k = 0; k < 32; k++) begin
            cke = k[4]; cs_n = k[3]; ras_n = k[2]; cas_n = k[1]; we_n = k[0];
            tick();
            chk($sformatf("R1 decode pattern %0d", k), cmd_o, ref_code(k));
        end

        // R2: each bank address maps to its own flag
        for (int b = 0; b < 4; b++) begin
            do_reset();
            put(4, b, 1'b0);
            chk($sformatf("R2 open bank %0d", b), bank_open_o, 1 << b);
        end

        // R3: cross-bank activate spacing
        for (int d = 1; d <= T_RRD + 1; d++) begin
            do_reset();
            put(4, 0, 1'b0); idle(d - 1); put(4, 1, 1'b0);
            chk($sformatf("R3 rrd d=%0d", d), v_rrd, (d < T_RRD) ? 1 : 0);
        end
        do_reset();
        put(4, 2, 1'b0); put(4, 2, 1'b0);
        chk("R3 same bank no rrd", v_rrd, 0);
        chk("R10 act to open bank", v_state, 1);

        // R4: activate to column
        for (int d = 1; d <= T_RCD + 1; d++) begin
            do_reset();
            put(4, 0, 1'b0); idle(d - 1); put((d % 2) ? 5 : 6, 0, 1'b0);
            chk($sformatf("R4 rcd d=%0d", d), v_rcd, (d < T_RCD) ? 1 : 0);
        end

        // R5: minimum active time
        for (int d = 1; d <= T_RAS + 1; d++) begin
            do_reset();
            put(4, 2, 1'b0); idle(d - 1); put(8, 2, 1'b0);
            chk($sformatf("R5 ras d=%0d", d), v_ras, (d < T_RAS) ? 1 : 0);
            chk($sformatf("R2 pre closes d=%0d", d), bank_open_o, 0);
        end

        // R6 and R7: precharge at 7, reactivate at d
        for (int d = T_RAS + 1; d <= T_RC + 2; d++) begin
            do_reset();
            put(4, 0, 1'b0); idle(T_RAS - 1); put(8, 0, 1'b0);
            idle(d - T_RAS - 1); put(4, 0, 1'b0);
            chk($sformatf("R6 rp d=%0d", d), v_rp, ((d - T_RAS) < T_RP) ? 1 : 0);
            chk($sformatf("R7 rc d=%0d", d), v_rc, (d < T_RC) ? 1 : 0);
        end

        // R8: write recovery before precharge
        for (int e = 4; e <= BL - 1 + T_WR + 1; e++) begin
            do_reset();
            put(4, 1, 1'b0); idle(T_RCD - 1); put(6, 1, 1'b0);
            idle(e - 1); put(8, 1, 1'b0);
            chk($sformatf("R8 wr e=%0d", e), v_wr, (e < BL - 1 + T_WR) ? 1 : 0);
            chk($sformatf("R5 no ras e=%0d", e), v_ras, 0);
        end

        // R6/R2: read with auto-precharge
        for (int d = BL + T_RP - 1; d <= BL + T_RP; d++) begin
            do_reset();
            put(4, 0, 1'b0); idle(T_RCD - 1); put(5, 0, 1'b1);
            chk("R2 read auto-precharge closes", bank_open_o, 0);
            idle(d - 1); put(4, 0, 1'b0);
            chk($sformatf("R6 rd-ap rp d=%0d", d), v_rp, (d < BL + T_RP) ? 1 : 0);
            chk($sformatf("R10 rd-ap no state d=%0d", d), v_state, 0);
        end

        // R6: write with auto-precharge
        for (int d = BL - 1 + T_WR + T_RP - 1; d <= BL - 1 + T_WR + T_RP; d++) begin
            do_reset();
            put(4, 3, 1'b0); idle(T_RCD - 1); put(6, 3, 1'b1);
            idle(d - 1); put(4, 3, 1'b0);
            chk($sformatf("R6 wr-ap rp d=%0d", d), v_rp, (d < BL - 1 + T_WR + T_RP) ? 1 : 0);
        end

        // R5/R2: precharge-all ignores bank address
        for (int t = 8; t <= 9; t++) begin
            do_reset();
            put(4, 0, 1'b0); put(0, 0, 1'b0); put(4, 3, 1'b0);
            idle(t - 3); put(8, 1, 1'b1);
            chk($sformatf("R2 pre-all t=%0d", t), bank_open_o, 0);
            chk($sformatf("R5 pre-all ras t=%0d", t), v_ras, (t - 2 < T_RAS) ? 1 : 0);
        end

        // R9: spacing after mode set
        for (int d = 1; d <= T_MRD + 1; d++) begin
            do_reset();
            put(1, 0, 1'b0); idle(d - 1); put(7, 0, 1'b0);
            chk($sformatf("R9 mrd d=%0d", d), v_mrd, (d < T_MRD) ? 1 : 0);
        end

        // R10: state rules
        do_reset();
        put(5, 2, 1'b0);
        chk("R10 read closed bank", v_state, 1);
        put(6, 1, 1'b0);
        chk("R10 write closed bank", v_state, 1);
        put(4, 2, 1'b0);
        chk("R10 act closed bank ok", v_state, 0);
        idle(3);
        put(1, 0, 1'b0);
        chk("R10 mode set with open bank", v_state, 1);
        idle(3);
        put(2, 0, 1'b0);
        chk("R10 refresh with open bank", v_state, 1);
        put(3, 0, 1'b0);
        chk("R10 self refresh with open bank", v_state, 1);
        put(8, 2, 1'b0);
        put(2, 0, 1'b0);
        chk("R10 refresh all closed", v_state, 0);

        done = 1'b1;
        finish_run();
    end
endmodule